// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Retained-Setting Controller

This block is the register core of a digitally controlled potentiometer. It holds the live wiper code that selects one of 128 taps. It also holds a modelled retained start-up code and a small control register. A serial bus front end, which is outside this block, passes it single-byte write and read requests and a pulse that marks the end of each bus transfer.

A mode bit in the control register decides what address 0 reaches. With the bit at 0, a write to address 0 moves the wiper at once and also stages the value for the retained register. The retained register then takes the value through a self-timed write. That write starts at the end-of-transfer pulse and runs for a parameterised number of clocks. A busy flag stays raised for the whole write. While the flag is raised, writes to the wiper and to the control register are refused. With the mode bit at 1, address 0 reaches the wiper only.

At power-up the wiper sits at mid-scale. When the supply is reported valid, the retained code is copied into the wiper, and requests are accepted from then on. Shutdown is requested by an active-low pin or by a control bit. Shutdown never alters the stored wiper code, so the tap returns to its earlier position when shutdown ends.

Top module: `dpot_regctl`

## Requirements
- R1: During and after synchronous reset, before the supply is valid, `tap` is 40h, `ready` is 0, `shutdown` is 0 and `rdata` is 00h. The control register resets to mode bit 0 and active bit 1.
- R2: In the first clock edge at which `supply_ok` is high and `ready` is 0, the wiper is loaded from the retained register and `ready` rises. Requests are ignored until `ready` is 1.
- R3: The address map is as follows. Address 0 is the wiper or retained register. Address 2 is the control byte, with bit 7 the mode bit (1 = wiper only), bit 6 the active bit (0 = shut down), bit 5 the busy flag and bits 4:0 reading 0. Addresses 1 and 3 read 00h, and writes to them change nothing.
- R4: With the mode bit at 1, a write to address 0 updates the wiper on the next edge and leaves the retained register and the busy flag untouched. A read of address 0 returns the wiper.
- R5: With the mode bit at 0, a write to address 0 updates the wiper on the next edge and stages the byte. The retained register takes the staged byte when the self-timed write ends. A read of address 0 returns the retained register.
- R6: At the first `bus_stop` pulse that follows a staged write, the busy flag rises on that edge. It stays at 1 for exactly NV_CYCLES cycles and then clears on the same edge that commits the retained register. A `bus_stop` pulse with nothing staged does not raise the flag.
- R7: While the busy flag is 1, writes to addresses 0 and 2 have no effect. Reads still work.
- R8: `shutdown` is registered. It is 1 one cycle after `shdn_n_pin` is low or the active bit is 0, and 0 one cycle after both are inactive.
- R9: Shutdown never changes the wiper code. `tap` holds its value through shutdown, and all registers can still be read and written during shutdown.
- R10: While `supply_ok` is low, `ready` is 0, the wiper returns to 40h, the control register returns to its defaults, requests are ignored, and an in-flight retained write is dropped. The retained register keeps its last committed value, and that value is recalled when the supply returns.
- R11: `rdata` changes only on the edge after an accepted read. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply valid for retained-register access |
| shdn_n_pin | input | 1 | Active-low shutdown pin |
| req_wr | input | 1 | Write request strobe |
| req_rd | input | 1 | Read request strobe |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| bus_stop | input | 1 | End-of-transfer pulse from the bus front end |
| tap | output | 7 | Selected tap, 00h nearest low terminal, 7Fh nearest high |
| shutdown | output | 1 | Registered shutdown to the resistor array |
| ready | output | 1 | Recall complete, requests accepted |
| rdata | output | 8 | Registered read data |

## Verification
The bench probes the last cycle of the self-timed write with a control read. A controller that cleared busy one cycle early would show 40h in that read instead of 60h. It tries wiper and control writes during the busy window. A controller that failed to block them would move the tap or lose its mode. It drops the supply in the middle of a retained write. A controller that still committed would then recall 10h instead of the earlier 5Ah. It also checks the one-cycle lag of the shutdown output from the control bit, and checks that reserved addresses neither read back data nor change state.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int DATA_W = 8;
    localparam int TAP_W  = 7;

    localparam logic [DATA_W-1:0] WIPER_PRESET = 8'h40;

    typedef enum logic [1:0] {
        REG_WIPER = 2'd0,
        REG_GAP   = 2'd1,
        REG_CTRL  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic vol_only;   // 1: address 0 reaches the wiper only
        logic active;     // 0: shutdown requested
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{vol_only: 1'b0, active: 1'b1};

    function automatic logic [DATA_W-1:0] ctrl_byte(ctrl_t c, logic busy);
        return {c.vol_only, c.active, busy, 5'b00000};
    endfunction

endpackage

// File: rtl/dpot_nv_store.sv
module dpot_nv_store
    import dpot_pkg::*;
#(
    parameter int               NV_CYCLES = 2_500_000,
    parameter logic [DATA_W-1:0] IVR_INIT = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drop,
    input  logic              stage_en,
    input  logic [DATA_W-1:0] stage_data,
    input  logic              stop,
    output logic              busy,
    output logic [DATA_W-1:0] ivr
);
    localparam int CNT_W = $clog2(NV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_CYCLES - 1);

    logic              pend;
    logic [DATA_W-1:0] staged;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ivr    <= IVR_INIT;
            busy   <= 1'b0;
            pend   <= 1'b0;
            cnt    <= '0;
            staged <= '0;
        end else if (drop) begin
            busy <= 1'b0;
            pend <= 1'b0;
            cnt  <= '0;
        end else begin
            if (busy) begin
                if (cnt == '0) begin
                    ivr  <= staged;
                    busy <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (stop && pend) begin
                busy <= 1'b1;
                cnt  <= CNT_LOAD;
                pend <= 1'b0;
            end
            if (stage_en) begin
                staged <= stage_data;
                pend   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dpot_shdn_ctl.sv
module dpot_shdn_ctl (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic ctrl_active,
    output logic shut
);
    always_ff @(posedge clk) begin
        if (rst) shut <= 1'b0;
        else     shut <= !pin_n || !ctrl_active;
    end
endmodule

// File: rtl/dpot_rd_mux.sv
module dpot_rd_mux
    import dpot_pkg::*;
(
    input  reg_sel_e          sel,
    input  ctrl_t             ctrl,
    input  logic              busy,
    input  logic [DATA_W-1:0] wiper,
    input  logic [DATA_W-1:0] ivr,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        unique case (sel)
            REG_WIPER: dout = ctrl.vol_only ? wiper : ivr;
            REG_CTRL:  dout = ctrl_byte(ctrl, busy);
            default:   dout = '0;
        endcase
    end
endmodule

// File: rtl/dpot_regctl.sv
module dpot_regctl
    import dpot_pkg::*;
#(
    parameter int               NV_CYCLES = 2_500_000,
    parameter logic [DATA_W-1:0] IVR_INIT = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              shdn_n_pin,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_stop,
    output logic [TAP_W-1:0]  tap,
    output logic              shutdown,
    output logic              ready,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] wiper_q;
    ctrl_t             ctrl_q;
    logic              ready_q;
    logic [DATA_W-1:0] rdata_q;
    logic              busy;
    logic [DATA_W-1:0] ivr;
    logic [DATA_W-1:0] rd_byte;
    reg_sel_e          sel;
    logic              live;
    logic              wr_ok;
    logic              stage_en;

    assign sel      = reg_sel_e'(req_addr);
    assign live     = supply_ok && ready_q;
    assign wr_ok    = live && req_wr && !busy;
    assign stage_en = wr_ok && (sel == REG_WIPER) && !ctrl_q.vol_only;

    dpot_nv_store #(.NV_CYCLES(NV_CYCLES), .IVR_INIT(IVR_INIT)) u_nv (
        .clk        (clk),
        .rst        (rst),
        .drop       (!supply_ok),
        .stage_en   (stage_en),
        .stage_data (req_wdata),
        .stop       (bus_stop),
        .busy       (busy),
        .ivr        (ivr)
    );

    dpot_rd_mux u_mux (
        .sel   (sel),
        .ctrl  (ctrl_q),
        .busy  (busy),
        .wiper (wiper_q),
        .ivr   (ivr),
        .dout  (rd_byte)
    );

    dpot_shdn_ctl u_shdn (
        .clk         (clk),
        .rst         (rst),
        .pin_n       (shdn_n_pin),
        .ctrl_active (ctrl_q.active),
        .shut        (shutdown)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper_q <= WIPER_PRESET;
            ctrl_q  <= CTRL_DEFAULT;
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else if (!supply_ok) begin
            wiper_q <= WIPER_PRESET;
            ctrl_q  <= CTRL_DEFAULT;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            wiper_q <= ivr;
            ready_q <= 1'b1;
        end else begin
            if (req_rd) rdata_q <= rd_byte;
            if (wr_ok) begin
                case (sel)
                    REG_WIPER: wiper_q <= req_wdata;
                    REG_CTRL:  ctrl_q  <= '{vol_only: req_wdata[7], active: req_wdata[6]};
                    default:   ;
                endcase
            end
        end
    end

    assign tap   = wiper_q[TAP_W-1:0];
    assign ready = ready_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/dpot_regctl_chk.sv
module dpot_regctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       shdn_n_pin,
    input logic       req_wr,
    input logic       req_rd,
    input logic [1:0] req_addr,
    input logic       bus_stop,
    input logic [6:0] tap,
    input logic       shutdown,
    input logic       ready,
    input logic [7:0] rdata,
    input logic       busy,
    input logic [7:0] ivr,
    input logic       ctrl_active,
    input logic       ctrl_vol
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (tap == 7'h40 && !ready && !shutdown));

    assert_recall_R2: assert property (@(posedge clk) disable iff (rst)
        (!ready && supply_ok) |=> (ready && tap == $past(ivr[6:0])));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (req_rd && ready && supply_ok && req_addr[0]) |=> (rdata == 8'h00));

    assert_ctrl_low_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (req_rd && ready && supply_ok && req_addr == 2'd2) |=> (rdata[4:0] == 5'd0));

    assert_vol_keeps_ivr_R4: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && ready && req_wr && req_addr == 2'd0 && ctrl_vol && !busy) |=> $stable(ivr));

    assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_stop));

    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && supply_ok && req_wr && req_addr == 2'd0) |=> $stable(tap));

    assert_pin_shutdown_R8: assert property (@(posedge clk) disable iff (rst)
        (!shdn_n_pin) |=> shutdown);

    assert_run_resumes_R8: assert property (@(posedge clk) disable iff (rst)
        (shdn_n_pin && ctrl_active) |=> !shutdown);

    assert_shutdown_keeps_tap_R9: assert property (@(posedge clk) disable iff (rst)
        (shutdown && ready && supply_ok && !req_wr) |=> $stable(tap));

    assert_supply_loss_R10: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok) |=> (!ready && tap == 7'h40 && !busy));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!req_rd) |=> $stable(rdata));
endmodule

bind dpot_regctl dpot_regctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .shdn_n_pin  (shdn_n_pin),
    .req_wr      (req_wr),
    .req_rd      (req_rd),
    .req_addr    (req_addr),
    .bus_stop    (bus_stop),
    .tap         (tap),
    .shutdown    (shutdown),
    .ready       (ready),
    .rdata       (rdata),
    .busy        (busy),
    .ivr         (ivr),
    .ctrl_active (ctrl_q.active),
    .ctrl_vol    (ctrl_q.vol_only)
);

// File: tb/dpot_regctl_tb.sv
`timescale 1ns/1ps
module dpot_regctl_tb;
    localparam int         NV   = 12;
    localparam logic [7:0] INIT = 8'h33;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b0;
    logic       shdn_n_pin = 1'b1;
    logic       req_wr = 1'b0;
    logic       req_rd = 1'b0;
    logic [1:0] req_addr = 2'd0;
    logic [7:0] req_wdata = 8'h00;
    logic       bus_stop = 1'b0;
    logic [6:0] tap;
    logic       shutdown;
    logic       ready;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dpot_regctl #(.NV_CYCLES(NV), .IVR_INIT(INIT)) u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .shdn_n_pin(shdn_n_pin),
        .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_stop(bus_stop), .tap(tap), .shutdown(shutdown), .ready(ready), .rdata(rdata)
    );

    // behavioural reference
    logic [7:0] m_wr = 8'h40, m_ivr = INIT, m_nvd = 8'h00, m_rdata = 8'h00;
    bit m_vol = 0, m_act = 1, m_busy = 0, m_pend = 0, m_ready = 0, m_sd = 0, started = 0;
    int m_cnt = 0;

    always @(posedge clk) begin
        bit ob, ov, oa;
        started = 1;
        ob = m_busy; ov = m_vol; oa = m_act;
        if (rst) begin
            m_wr = 8'h40; m_ivr = INIT; m_nvd = 0; m_rdata = 0; m_vol = 0; m_act = 1;
            m_busy = 0; m_pend = 0; m_ready = 0; m_sd = 0; m_cnt = 0;
        end else begin
            m_sd = !shdn_n_pin || !oa;
            if (!supply_ok) begin
                m_wr = 8'h40; m_vol = 0; m_act = 1; m_busy = 0; m_pend = 0; m_ready = 0;
            end else if (!m_ready) begin
                m_wr = m_ivr; m_ready = 1;
            end else begin
                if (req_rd) begin
                    if (req_addr == 2'd0)      m_rdata = ov ? m_wr : m_ivr;
                    else if (req_addr == 2'd2) m_rdata = {ov, oa, ob, 5'b0};
                    else                       m_rdata = 8'h00;
                end
                if (ob) begin
                    if (m_cnt == 0) begin m_ivr = m_nvd; m_busy = 0; end
                    else m_cnt--;
                end else if (bus_stop && m_pend) begin
                    m_busy = 1; m_cnt = NV - 1; m_pend = 0;
                end
                if (req_wr && !ob) begin
                    if (req_addr == 2'd0) begin
                        m_wr = req_wdata;
                        if (!ov) begin m_nvd = req_wdata; m_pend = 1; end
                    end else if (req_addr == 2'd2) begin
                        m_vol = req_wdata[7]; m_act = req_wdata[6];
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp += 4;
            if (tap !== m_wr[6:0]) begin n_bad++; $display("FAIL R9 tap got %h exp %h", tap, m_wr[6:0]); end
            if (shutdown !== m_sd) begin n_bad++; $display("FAIL R8 shutdown got %b exp %b", shutdown, m_sd); end
            if (ready !== m_ready) begin n_bad++; $display("FAIL R2 ready got %b exp %b", ready, m_ready); end
            if (rdata !== m_rdata) begin n_bad++; $display("FAIL R11 rdata got %h exp %h", rdata, m_rdata); end
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        req_wr = 1; req_addr = a; req_wdata = d; tick(); req_wr = 0;
    endtask

    task automatic do_rd(input logic [1:0] a);
        req_rd = 1; req_addr = a; tick(); req_rd = 0;
    endtask

    task automatic do_stop();
        bus_stop = 1; tick(); bus_stop = 0;
    endtask

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 0; tick();
        chk({1'b0, tap}, 8'h40, "R1 tap");
        chk({7'b0, ready}, 8'h00, "R1 ready");
        chk({7'b0, shutdown}, 8'h00, "R1 shutdown");
        chk(rdata, 8'h00, "R1 rdata");
        do_wr(2'd0, 8'h11);
        chk({1'b0, tap}, 8'h40, "R10 write ignored without supply");
        supply_ok = 1; tick();
        chk({7'b0, ready}, 8'h01, "R2 ready");
        chk({1'b0, tap}, INIT, "R2 recall");
        do_rd(2'd2); chk(rdata, 8'h40, "R3 ctrl default");
        do_rd(2'd1); chk(rdata, 8'h00, "R3 reserved read");
        do_wr(2'd1, 8'hFF); do_rd(2'd2); chk(rdata, 8'h40, "R3 reserved write");
        chk({1'b0, tap}, INIT, "R3 tap untouched");
        do_rd(2'd3); chk(rdata, 8'h00, "R3 spare read");
        do_wr(2'd2, 8'hC0); do_wr(2'd0, 8'h15);
        chk({1'b0, tap}, 8'h15, "R4 tap");
        do_rd(2'd0); chk(rdata, 8'h15, "R4 read wiper");
        do_stop(); do_rd(2'd2); chk(rdata, 8'hC0, "R4 no busy");
        do_wr(2'd2, 8'h40); do_wr(2'd0, 8'h5A);
        chk({1'b0, tap}, 8'h5A, "R5 tap");
        do_rd(2'd0); chk(rdata, INIT, "R5 retained unchanged");
        do_stop();
        do_rd(2'd2); chk(rdata, 8'h60, "R6 busy set");
        do_wr(2'd0, 8'h01); chk({1'b0, tap}, 8'h5A, "R7 wiper blocked");
        do_wr(2'd2, 8'h00);
        do_rd(2'd2); chk(rdata, 8'h60, "R7 ctrl blocked");
        do_rd(2'd0); chk(rdata, INIT, "R7 not yet committed");
        repeat (6) tick();
        do_rd(2'd2); chk(rdata, 8'h60, "R6 busy last cycle");
        do_rd(2'd2); chk(rdata, 8'h40, "R6 busy cleared");
        do_rd(2'd0); chk(rdata, 8'h5A, "R5 committed");
        shdn_n_pin = 0; tick();
        chk({7'b0, shutdown}, 8'h01, "R8 pin shutdown");
        chk({1'b0, tap}, 8'h5A, "R9 tap held");
        do_wr(2'd2, 8'hC0); do_wr(2'd0, 8'h22);
        chk({1'b0, tap}, 8'h22, "R9 write in shutdown");
        do_rd(2'd0); chk(rdata, 8'h22, "R9 read in shutdown");
        shdn_n_pin = 1; tick();
        chk({7'b0, shutdown}, 8'h00, "R8 pin release");
        chk({1'b0, tap}, 8'h22, "R9 tap restored");
        do_wr(2'd2, 8'h80);
        chk({7'b0, shutdown}, 8'h00, "R8 bit lag");
        tick();
        chk({7'b0, shutdown}, 8'h01, "R8 bit shutdown");
        do_wr(2'd2, 8'hC0); tick();
        chk({7'b0, shutdown}, 8'h00, "R8 bit release");
        do_wr(2'd2, 8'h40); do_wr(2'd0, 8'h10); do_stop();
        repeat (3) tick();
        supply_ok = 0; tick();
        chk({7'b0, ready}, 8'h00, "R10 ready low");
        chk({1'b0, tap}, 8'h40, "R10 preset");
        supply_ok = 1; tick();
        chk({1'b0, tap}, 8'h5A, "R10 dropped write");
        do_rd(2'd2); chk(rdata, 8'h40, "R10 ctrl defaults");
        repeat (2) tick();
        chk(rdata, 8'h40, "R11 rdata hold");
        do_rd(2'd1); chk(rdata, 8'h00, "R11 rdata update");
        repeat (2) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule